// File: doc/BRIEF.md
# Serial ADC Command Responder

This block stands in for an eight-channel, ten-bit serial converter so that an SPI master controller can be checked without the real chip. It watches chip-select, the serial clock and the master-out line, and decodes a short command: a start bit, a mode bit and a three-bit channel number. It then answers on the master-in line with a null bit followed by the ten-bit value of the addressed channel. The value of each channel comes from a parallel input bus, so a bench can set the answer it expects.

The serial pins are brought into the fast system clock through a synchronizer, and serial-clock edges are found there. The command is read on rising serial-clock edges. The reply changes after falling edges, so the master can sample each bit on the next rising edge. A one-cycle done pulse and the decoded mode and channel let a bench match every reply against the command that produced it.

Top module: `spi_adc_responder`

## Requirements
- R1: While chip-select is high, `miso_oe` is 0 and `miso` is 0, and any half-received command or half-sent reply is dropped. The next transfer after chip-select falls is decoded from scratch. While chip-select is low, `miso_oe` is 1.
- R2: The command is read MSB first on rising serial-clock edges. It is a start bit of 1, then a mode bit (1 = single-ended, 0 = differential), then a three-bit channel number, MSB first. After the command, `cmd_mode` shows the mode bit and `cmd_chan` shows the channel number. Both hold until the next command completes.
- R3: Zeros on `mosi` before the first 1 after chip-select falls are ignored. The first 1 is taken as the start bit.
- R4: `miso` stays 0 from chip-select falling until the first result bit appears. The bit the master samples on the rising edge right after the last channel bit is a null bit of 0.
- R5: The result is the ten-bit value of the addressed channel from `ch_values`, where channel k occupies bits [10k+9:10k]. It is sent MSB first, one bit per serial-clock period, and the master samples it on rising edges 7 to 16 counted from the start bit. The same value is sent in both modes. An all-ones input gives 1023.
- R6: The channel value is captured when the last channel bit is received. Later changes to `ch_values` do not alter the reply that is in progress.
- R7: If chip-select stays low after the tenth result bit, `miso` is 0 on every later rising edge until chip-select rises.
- R8: `done` pulses for exactly one system clock after the rising edge that samples the last result bit. A transfer that is cut short by chip-select gives no pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, well above the serial clock rate |
| rst | input | 1 | Synchronous active-high reset |
| cs_n | input | 1 | Chip-select, active low |
| sclk | input | 1 | Serial clock from the master, idle low |
| mosi | input | 1 | Command bits from the master |
| ch_values | input | NCH*RES | Per-channel conversion values, channel k at [RES*k +: RES] |
| miso | output | 1 | Reply bit to the master |
| miso_oe | output | 1 | High while the reply line is driven |
| done | output | 1 | One-cycle pulse after a complete reply |
| cmd_mode | output | 1 | Mode bit of the last complete command |
| cmd_chan | output | CH_W | Channel number of the last complete command |

## Verification
The hardest case to reach from the ports is chip-select rising in the middle of a transfer. One abort is needed while the command is still being read, and another after the reply has started streaming. Only then does a missing done pulse and a clean following transfer show that nothing was left behind. The bench drives both aborts on purpose and follows each with a normal transfer. It also changes a channel's input while that channel's reply is being sent, and it adds leading zeros and extra trailing clocks to cover the other hard-to-reach cases.

// File: rtl/adc_resp_pkg.sv
package adc_resp_pkg;

  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_CMD  = 3'd1,
    ST_GAP  = 3'd2,
    ST_NULL = 3'd3,
    ST_SEND = 3'd4,
    ST_TAIL = 3'd5
  } seq_state_t;

  function automatic int cnt_width(input int a, input int b);
    return $clog2(((a > b) ? a : b) + 1);
  endfunction

endpackage

// File: rtl/adc_resp_sync.sv
module adc_resp_sync #(
  parameter int           W       = 3,
  parameter int           STAGES  = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [STAGES-1:0][W-1:0] stg;

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < STAGES; i++) stg[i] <= RST_VAL;
    end else begin
      stg[0] <= d;
      for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
    end
  end

  assign q = stg[STAGES-1];

endmodule

// File: rtl/adc_resp_fsm.sv
module adc_resp_fsm
  import adc_resp_pkg::*;
#(
  parameter int CH_W = 3,
  parameter int RES  = 10
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            cs_idle,
  input  logic            sclk_rise,
  input  logic            sclk_fall,
  input  logic            mosi_s,
  output seq_state_t      state,
  output logic            load,
  output logic [CH_W-1:0] load_chan,
  output logic            shift,
  output logic            done,
  output logic            mode_q,
  output logic [CH_W-1:0] chan_q
);

  localparam int CMD_W = 1 + CH_W;
  localparam int CNT_W = cnt_width(RES, CMD_W);

  logic [CMD_W-2:0] sr;
  logic [CMD_W-1:0] sr_next;
  logic [CNT_W-1:0] cnt;
  logic             cmd_last;

  assign sr_next   = {sr, mosi_s};
  assign cmd_last  = (state == ST_CMD) && sclk_rise && (cnt == CNT_W'(CMD_W - 1));
  assign load      = cmd_last;
  assign load_chan = sr_next[CH_W-1:0];
  assign shift     = (state == ST_SEND) && sclk_fall && (cnt != '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      state  <= ST_IDLE;
      cnt    <= '0;
      sr     <= '0;
      done   <= 1'b0;
      mode_q <= 1'b0;
      chan_q <= '0;
    end else if (cs_idle) begin
      state <= ST_IDLE;
      cnt   <= '0;
      sr    <= '0;
      done  <= 1'b0;
    end else begin
      done <= 1'b0;
      unique case (state)
        ST_IDLE: begin
          if (sclk_rise && mosi_s) begin
            state <= ST_CMD;
            cnt   <= '0;
          end
        end
        ST_CMD: begin
          if (sclk_rise) begin
            sr <= sr_next[CMD_W-2:0];
            if (cmd_last) begin
              state  <= ST_GAP;
              mode_q <= sr_next[CMD_W-1];
              chan_q <= sr_next[CH_W-1:0];
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
        end
        ST_GAP: begin
          if (sclk_fall) state <= ST_NULL;
        end
        ST_NULL: begin
          if (sclk_fall) begin
            state <= ST_SEND;
            cnt   <= CNT_W'(RES - 1);
          end
        end
        ST_SEND: begin
          if (sclk_rise && (cnt == '0)) begin
            state <= ST_TAIL;
            done  <= 1'b1;
          end else if (shift) begin
            cnt <= cnt - 1'b1;
          end
        end
        ST_TAIL: state <= ST_TAIL;
        default: state <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/adc_resp_txshift.sv
module adc_resp_txshift #(
  parameter int RES = 10
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           load,
  input  logic [RES-1:0] din,
  input  logic           shift,
  output logic           msb
);

  logic [RES-1:0] sh;

  always_ff @(posedge clk) begin
    if (rst)        sh <= '0;
    else if (load)  sh <= din;
    else if (shift) sh <= {sh[RES-2:0], 1'b0};
  end

  assign msb = sh[RES-1];

endmodule

// File: rtl/spi_adc_responder.sv
module spi_adc_responder
  import adc_resp_pkg::*;
#(
  parameter int  NCH         = 8,
  parameter int  RES         = 10,
  parameter int  SYNC_STAGES = 2,
  localparam int CH_W        = $clog2(NCH)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               cs_n,
  input  logic               sclk,
  input  logic               mosi,
  input  logic [NCH*RES-1:0] ch_values,
  output logic               miso,
  output logic               miso_oe,
  output logic               done,
  output logic               cmd_mode,
  output logic [CH_W-1:0]    cmd_chan
);

  logic [2:0]      pins_s;
  logic            cs_s, sclk_s, mosi_s, sclk_prev;
  logic            sclk_rise, sclk_fall;
  seq_state_t      seq_state;
  logic            ld, sh, tx_bit;
  logic [CH_W-1:0] ld_chan;
  logic [RES-1:0]  ch_arr [NCH];
  logic            miso_r, oe_r;

  adc_resp_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b100)) u_sync (
    .clk(clk), .rst(rst), .d({cs_n, sclk, mosi}), .q(pins_s)
  );

  assign cs_s   = pins_s[2];
  assign sclk_s = pins_s[1];
  assign mosi_s = pins_s[0];

  always_ff @(posedge clk) begin
    if (rst) sclk_prev <= 1'b0;
    else     sclk_prev <= sclk_s;
  end

  assign sclk_rise = sclk_s & ~sclk_prev;
  assign sclk_fall = ~sclk_s & sclk_prev;

  generate
    for (genvar k = 0; k < NCH; k++) begin : g_ch
      assign ch_arr[k] = ch_values[k*RES +: RES];
    end
  endgenerate

  adc_resp_fsm #(.CH_W(CH_W), .RES(RES)) u_fsm (
    .clk(clk), .rst(rst), .cs_idle(cs_s),
    .sclk_rise(sclk_rise), .sclk_fall(sclk_fall), .mosi_s(mosi_s),
    .state(seq_state), .load(ld), .load_chan(ld_chan), .shift(sh),
    .done(done), .mode_q(cmd_mode), .chan_q(cmd_chan)
  );

  adc_resp_txshift #(.RES(RES)) u_tx (
    .clk(clk), .rst(rst), .load(ld), .din(ch_arr[ld_chan]),
    .shift(sh), .msb(tx_bit)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      miso_r <= 1'b0;
      oe_r   <= 1'b0;
    end else begin
      oe_r   <= ~cs_s;
      miso_r <= ~cs_s && (seq_state == ST_SEND) && tx_bit;
    end
  end

  assign miso    = miso_r;
  assign miso_oe = oe_r;

endmodule

// File: rtl/adc_resp_chk.sv
module adc_resp_chk
  import adc_resp_pkg::*;
(
  input logic       clk,
  input logic       rst,
  input logic       cs_s,
  input logic       miso,
  input logic       miso_oe,
  input logic       done,
  input seq_state_t state
);

  // R1
  cs_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    cs_s |=> (!miso_oe && !miso));

  // R1
  cs_drive_chk: assert property (@(posedge clk) disable iff (rst)
    !cs_s |=> miso_oe);

  // R4
  pre_result_low_chk: assert property (@(posedge clk) disable iff (rst)
    (state == ST_IDLE || state == ST_CMD || state == ST_GAP || state == ST_NULL) |=> !miso);

  // R7
  tail_low_chk: assert property (@(posedge clk) disable iff (rst)
    (state == ST_TAIL) |=> !miso);

  // R8
  done_single_chk: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R8
  done_after_send_chk: assert property (@(posedge clk) disable iff (rst)
    done |-> (state == ST_TAIL));

endmodule

bind spi_adc_responder adc_resp_chk u_chk (
  .clk(clk), .rst(rst), .cs_s(cs_s), .miso(miso),
  .miso_oe(miso_oe), .done(done), .state(seq_state)
);

// File: tb/tb_spi_adc_responder.sv
module tb_spi_adc_responder;

  localparam int NCH  = 8;
  localparam int RES  = 10;
  localparam int HALF = 8;

  logic clk = 1'b0, rst = 1'b1, cs_n = 1'b1, sclk = 1'b0, mosi = 1'b0;
  logic [NCH*RES-1:0] chv;
  wire        miso, miso_oe, done, cmd_mode;
  wire [2:0]  cmd_chan;

  spi_adc_responder dut (
    .clk(clk), .rst(rst), .cs_n(cs_n), .sclk(sclk), .mosi(mosi),
    .ch_values(chv), .miso(miso), .miso_oe(miso_oe), .done(done),
    .cmd_mode(cmd_mode), .cmd_chan(cmd_chan)
  );

  always #2.5 clk = ~clk;

  typedef struct packed {
    logic           md;
    logic [2:0]     ch;
    logic [RES-1:0] val;
  } exp_t;

  exp_t        expq[$];
  exp_t        mon_e;
  logic [31:0] rx_sr = '0;
  int          tests = 0, fails = 0, n_push = 0, n_done = 0;
  bit          ended = 0;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic half_wait();
    repeat (HALF) @(negedge clk);
  endtask

  task automatic clk_bit(input logic b);
    mosi = b;
    half_wait();
    sclk = 1'b1;
    half_wait();
    sclk = 1'b0;
  endtask

  // master samples miso on every rising serial-clock edge
  always @(posedge sclk) if (!cs_n) rx_sr <= {rx_sr[30:0], miso};

  // scoreboard monitor
  always @(negedge clk) begin
    if (!rst && done) begin
      n_done++;
      if (expq.size() == 0) begin
        check(1'b0, "R8 done without pending transfer", 1, 0);
      end else begin
        mon_e = expq.pop_front();
        check(cmd_mode == mon_e.md, "R2 mode", int'(cmd_mode), int'(mon_e.md));
        check(cmd_chan == mon_e.ch, "R2 channel", int'(cmd_chan), int'(mon_e.ch));
        check(rx_sr[9:0] == mon_e.val, "R5 result", int'(rx_sr[9:0]), int'(mon_e.val));
        check(rx_sr[10] == 1'b0, "R4 null bit", int'(rx_sr[10]), 0);
        check(rx_sr[11] == 1'b0, "R4 low before null", int'(rx_sr[11]), 0);
      end
    end
  end

  task automatic cs_up();
    half_wait();
    cs_n = 1'b1;
    half_wait();
    half_wait();
    check(miso_oe == 1'b0, "R1 oe low when deselected", int'(miso_oe), 0);
    check(miso == 1'b0, "R1 miso low when deselected", int'(miso), 0);
  endtask

  task automatic xfer(input int lz, input bit md, input logic [2:0] ch,
                      input int extra, input bit poke);
    expq.push_back({md, ch, chv[ch*RES +: RES]});
    n_push++;
    cs_n = 1'b0;
    half_wait();
    check(miso_oe == 1'b1, "R1 oe high when selected", int'(miso_oe), 1);
    repeat (lz) clk_bit(1'b0);
    clk_bit(1'b1);
    clk_bit(md);
    for (int i = 2; i >= 0; i--) clk_bit(ch[i]);
    for (int k = 0; k < 11; k++) begin
      if (poke && k == 2) chv[ch*RES +: RES] = ~chv[ch*RES +: RES]; // R6
      clk_bit(1'b0);
    end
    for (int e = 0; e < extra; e++) begin
      mosi = 1'b0;
      half_wait();
      check(miso == 1'b0, "R7 miso low after reply", int'(miso), 0);
      sclk = 1'b1;
      half_wait();
      sclk = 1'b0;
    end
    cs_up();
  endtask

  task automatic abort_xfer(input int nbits);
    cs_n = 1'b0;
    half_wait();
    clk_bit(1'b1);
    clk_bit(1'b1);
    for (int i = 0; i < nbits; i++) clk_bit(1'b1);
    cs_up();
  endtask

  task automatic finish_run();
    if (!ended) begin
      ended = 1;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!ended) begin
      tests++;
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      finish_run();
    end
  end

  initial begin
    for (int k = 0; k < NCH; k++) chv[k*RES +: RES] = RES'((k * 97 + 13) & 10'h3FF);
    chv[0*RES +: RES] = 10'h3FF;
    chv[5*RES +: RES] = 10'h2A5;
    chv[3*RES +: RES] = 10'h155;
    chv[7*RES +: RES] = 10'h001;
    chv[2*RES +: RES] = 10'h3C3;
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check(miso_oe == 1'b0, "R1 reset oe", int'(miso_oe), 0);
    check(miso == 1'b0, "R1 reset miso", int'(miso), 0);
    check(done == 1'b0, "R8 reset done", int'(done), 0);

    xfer(0, 1'b1, 3'd0, 0, 1'b0);   // R5 full scale 1023 on channel 0
    xfer(3, 1'b1, 3'd5, 0, 1'b0);   // R3 leading zeros
    xfer(0, 1'b0, 3'd3, 0, 1'b0);   // R5 differential mode, same value
    xfer(1, 1'b1, 3'd7, 4, 1'b0);   // R7 trailing clocks
    xfer(0, 1'b1, 3'd2, 0, 1'b1);   // R6 input changes mid-reply
    xfer(0, 1'b1, 3'd2, 0, 1'b0);   // R6 new value taken next time
    abort_xfer(1);                  // R1 abort inside command
    xfer(0, 1'b0, 3'd6, 0, 1'b0);
    abort_xfer(6);                  // R1 abort inside reply
    xfer(2, 1'b1, 3'd1, 2, 1'b0);
    xfer(0, 1'b1, 3'd4, 0, 1'b0);

    repeat (20) @(negedge clk);
    check(n_done == n_push, "R8 one done per full transfer", n_done, n_push);
    check(expq.size() == 0, "R8 scoreboard drained", expq.size(), 0);
    finish_run();
  end

endmodule